// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test port built around the standard sixteen-state controller, stepped by TMS on each rising edge of TCK. It holds a 3-bit instruction register and three data paths: a 1-bit bypass stage, a 32-bit identification word and a boundary register of parameterized length (70 cells by default). The boundary register only captures and shifts a parallel vector of pad values. It has no update stage and never drives the pads.

Two instructions that normally drive pads are reduced here. The external-test code and the sample-Z code both sample the pads like the sample code does, and both raise a flag that tells the functional logic to float its outputs. TDO changes on the falling edge of TCK, and a companion enable is high only while a shift state is active. The port has no dedicated test reset pin. It reaches its reset state through a power-on reset, or through five rising TCK edges with TMS held high.

Top module: `scan_port`

## Requirements
- R1: While power-on reset is asserted and after it is released, `tdo_oe` is 0 and `outs_hiz` is 0. The identification instruction (code 001) is active, so the first data scan returns the identification word.
- R2: Five consecutive rising TCK edges with TMS=1 bring the controller to Test-Logic-Reset from any state. The rising edge that enters that state also makes code 001 the active instruction, which clears `outs_hiz`.
- R3: TMS and TDI are sampled on rising TCK edges. `tdo` and `tdo_oe` change only on falling edges. `tdo_oe` is 1 exactly after a falling edge seen while the controller is in Shift-IR or Shift-DR.
- R4: Capture-IR loads the instruction shift register with 001, so the first three bits that Shift-IR presents on `tdo` are 1, 0, 0.
- R5: A shifted instruction does not change the active instruction in Shift-IR, Exit-IR, Pause-IR or Update-IR. It takes effect on the rising edge that leaves Update-IR.
- R6: Under code 001, Capture-DR loads the identification word and shifts it out LSB first. Its fields are: bit 0 = 1, bits 11:1 = vendor parameter, bits 17:12 = reserved parameter, bits 22:18 = 00011, bits 27:23 = 00111, bits 31:28 = revision parameter.
- R7: TDI enters the MSB of the selected register and `tdo` comes from its LSB. A bit shifted into the 32-bit identification path appears on `tdo` 32 shifts later.
- R8: Code 111 selects the bypass stage. It captures 0, and each TDI bit reappears on `tdo` one shift later.
- R9: The reserved codes 011, 101 and 110 behave as code 111 and leave `outs_hiz` at 0.
- R10: Codes 000, 010 and 100 select the boundary register. Capture-DR loads `pads`, which shifts out with pad bit 0 first. `outs_hiz` is 1 under 000 and 010, and 0 under 100.
- R11: Under code 100, Update-DR preloads nothing. The next capture again returns the current `pads` and not the data shifted in, and `outs_hiz` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Controller mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pads | input | BSR_LEN | Pad values sampled by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| outs_hiz | output | 1 | Requests the functional outputs to float |

## Verification
The pad vector is captured under each boundary code using several distinct vectors, including a vector and its complement. This shows that each code selects the capture path and distinguishes the three codes by the float flag. The identification path is scanned once with all-zero TDI, which checks the field layout. It is scanned again 40 bits long with a marked TDI pattern, which shows the shift length and the MSB-in, LSB-out direction. The bypass and reserved codes are shifted with asymmetric bit patterns, so that a missing or extra delay stage shows up. Instruction loads are stopped in Pause-IR and Update-IR, and the 5-ones reset is started from Shift-DR with a float code active, so that the exact edge of each instruction change is pinned down.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   localparam int IR_W = 3;
   typedef logic [IR_W-1:0] instr_t;

   localparam instr_t OP_EXTEST   = 3'b000;
   localparam instr_t OP_IDCODE   = 3'b001;
   localparam instr_t OP_SAMPLE_Z = 3'b010;
   localparam instr_t OP_SAMPLE   = 3'b100;
   localparam instr_t OP_BYPASS   = 3'b111;

   typedef enum logic [1:0] {PATH_BYPASS, PATH_IDENT, PATH_BOUNDARY} dr_path_t;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      case (s)
         ST_RESET:  return m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
         default:   return ST_RESET;
      endcase
   endfunction

endpackage

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
   import scan_port_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_RESET;
      else        state <= tap_next(state, tms);
   end

endmodule

// File: rtl/scan_port_instr.sv
module scan_port_instr
   import scan_port_pkg::*;
#(
   parameter int W = IR_W
) (
   input  logic         tck,
   input  logic         por_n,
   input  logic         tms,
   input  logic         tdi,
   input  tap_state_t   state,
   output logic [W-1:0] ir_sh,
   output logic [W-1:0] active,
   output dr_path_t     path,
   output logic         float_req
);

   localparam logic [W-1:0] CAP_PATTERN = W'(2'b01);
   localparam logic [W-1:0] DEFAULT_OP  = W'(OP_IDCODE);

   if (W < 2) begin : g_bad_width
      $error("scan_port_instr: W must be at least 2");
   end

   logic entering_reset;
   assign entering_reset = (state == ST_RESET) || (state == ST_SEL_IR && tms);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sh <= CAP_PATTERN;
      end else if (state == ST_CAP_IR) begin
         ir_sh <= CAP_PATTERN;
      end else if (state == ST_SH_IR) begin
         ir_sh <= {tdi, ir_sh[W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                 active <= DEFAULT_OP;
      else if (entering_reset)    active <= DEFAULT_OP;
      else if (state == ST_UPD_IR) active <= ir_sh;
   end

   always_comb begin
      path      = PATH_BYPASS;
      float_req = 1'b0;
      case (active)
         W'(OP_IDCODE):   path = PATH_IDENT;
         W'(OP_SAMPLE):   path = PATH_BOUNDARY;
         W'(OP_EXTEST),
         W'(OP_SAMPLE_Z): begin
            path      = PATH_BOUNDARY;
            float_req = 1'b1;
         end
         default:         path = PATH_BYPASS;
      endcase
   end

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
   import scan_port_pkg::*;
#(
   parameter int          BSR_LEN = 70,
   parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_t         state,
   input  dr_path_t           path,
   input  logic [BSR_LEN-1:0] pads,
   output logic               lsb
);

   logic               byp;
   logic [31:0]        id_sh;
   logic [BSR_LEN-1:0] bsr;
   logic [BSR_LEN-1:0] bsr_shifted;

   if (BSR_LEN == 1) begin : g_bsr_single
      assign bsr_shifted = tdi;
   end else begin : g_bsr_multi
      assign bsr_shifted = {tdi, bsr[BSR_LEN-1:1]};
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp   <= 1'b0;
         id_sh <= '0;
         bsr   <= '0;
      end else if (state == ST_CAP_DR) begin
         case (path)
            PATH_IDENT:    id_sh <= ID_WORD;
            PATH_BOUNDARY: bsr   <= pads;
            default:       byp   <= 1'b0;
         endcase
      end else if (state == ST_SH_DR) begin
         case (path)
            PATH_IDENT:    id_sh <= {tdi, id_sh[31:1]};
            PATH_BOUNDARY: bsr   <= bsr_shifted;
            default:       byp   <= tdi;
         endcase
      end
   end

   always_comb begin
      case (path)
         PATH_IDENT:    lsb = id_sh[0];
         PATH_BOUNDARY: lsb = bsr[0];
         default:       lsb = byp;
      endcase
   end

endmodule

// File: rtl/scan_port.sv
module scan_port
   import scan_port_pkg::*;
#(
   parameter int          BSR_LEN     = 70,
   parameter logic [3:0]  REV_CODE    = 4'h0,
   parameter logic [5:0]  RSVD_CODE   = 6'h00,
   parameter logic [10:0] VENDOR_CODE = 11'h15B
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pads,
   output logic               tdo,
   output logic               tdo_oe,
   output logic               outs_hiz
);

   localparam logic [4:0]  DEPTH_CODE = 5'b00111;
   localparam logic [4:0]  WIDTH_CODE = 5'b00011;
   localparam logic [31:0] ID_WORD    =
      {REV_CODE, DEPTH_CODE, WIDTH_CODE, RSVD_CODE, VENDOR_CODE, 1'b1};

   if (BSR_LEN < 1) begin : g_bad_len
      $error("scan_port: BSR_LEN must be at least 1");
   end

   tap_state_t state;
   instr_t     ir_sh;
   instr_t     active_ir;
   dr_path_t   path;
   logic       dr_lsb;

   scan_port_ctrl u_ctrl (
      .tck(tck), .por_n(por_n), .tms(tms), .state(state)
   );

   scan_port_instr #(.W(IR_W)) u_ir (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .state(state),
      .ir_sh(ir_sh), .active(active_ir), .path(path), .float_req(outs_hiz)
   );

   scan_port_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
      .tck(tck), .por_n(por_n), .tdi(tdi), .state(state), .path(path),
      .pads(pads), .lsb(dr_lsb)
   );

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
         tdo    <= (state == ST_SH_IR) ? ir_sh[0] : dr_lsb;
      end
   end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
   import scan_port_pkg::*;
(
   input logic       tck,
   input logic       por_n,
   input logic       tms,
   input tap_state_t state,
   input instr_t     active,
   input instr_t     ir_sh,
   input logic       tdo_oe,
   input logic       outs_hiz
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)          ones_cnt <= '0;
      else if (!tms)       ones_cnt <= '0;
      else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
   end

   assert_five_ones_R2: assert property (@(posedge tck) disable iff (!por_n)
      (ones_cnt == 3'd5) |-> (state == ST_RESET));

   assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET) |-> (active == OP_IDCODE));

   assert_oe_shift_R3: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

   assert_cap_pattern_R4: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

   assert_update_only_R5: assert property (@(posedge tck) disable iff (!por_n)
      !$stable(active) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_SEL_IR
                            || $past(state) == ST_RESET));

   assert_float_source_R10: assert property (@(posedge tck) disable iff (!por_n)
      $rose(outs_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

bind scan_port scan_port_chk u_chk (
   .tck(tck), .por_n(por_n), .tms(tms), .state(state), .active(active_ir),
   .ir_sh(ir_sh), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz)
);

// File: tb/scan_port_test.sv
module scan_port_test;

   localparam int CLK_P = 20;
   localparam int NB    = 70;
   localparam logic [3:0]  REV  = 4'h2;
   localparam logic [5:0]  RSVD = 6'h00;
   localparam logic [10:0] VEND = 11'h15B;
   localparam logic [31:0] EXP_ID = {REV, 5'b00111, 5'b00011, RSVD, VEND, 1'b1};

   logic          tck = 1'b0;
   logic          por_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic [NB-1:0] pads = '0;
   logic          tdo, tdo_oe, outs_hiz;
   int            checks = 0;
   int            errors = 0;
   bit            done = 0;

   scan_port #(.BSR_LEN(NB), .REV_CODE(REV), .RSVD_CODE(RSVD), .VENDOR_CODE(VEND)) uut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pads(pads),
      .tdo(tdo), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz)
   );

   always #(CLK_P/2) tck = ~tck;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) begin
         cap[i] = tdo;
         step(i == 2, code[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
      dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic t_power_on;
      logic [127:0] o;
      chk(tdo_oe == 1'b0, "R1 tdo_oe after reset", tdo_oe, 0);
      chk(outs_hiz == 1'b0, "R1 outs_hiz after reset", outs_hiz, 0);
      step(0, 0);
      scan_dr(32, '0, o);
      chk(o[31:0] == EXP_ID, "R1 R6 identification word", o[31:0], EXP_ID);
   endtask

   task automatic t_id_passthrough;
      logic [127:0] o;
      logic [127:0] din = 128'hA5;
      scan_dr(40, din, o);
      chk(o[31:0] == EXP_ID, "R6 identification recapture", o[31:0], EXP_ID);
      chk(o[39:32] == din[7:0], "R7 TDI emerges after 32 shifts", o[39:32], din[7:0]);
   endtask

   task automatic t_ir_capture;
      logic [2:0] cap;
      load_ir(3'b111, cap);
      chk(cap == 3'b001, "R4 capture pattern", cap, 3'b001);
   endtask

   task automatic t_bypass;
      logic [127:0] o;
      logic [127:0] din = 128'hB3;
      scan_dr(8, din, o);
      chk(o[0] == 1'b0, "R8 bypass captures 0", o[0], 0);
      chk(o[7:1] == din[6:0], "R8 one-shift delay", o[7:1], din[6:0]);
   endtask

   task automatic t_tdo_edge;
      step(1, 0); step(0, 0); step(0, 0);
      chk(tdo_oe == 1'b1, "R3 tdo_oe in Shift-DR", tdo_oe, 1);
      tms = 0; tdi = 1;
      @(posedge tck); #1;
      chk(tdo == 1'b0, "R3 tdo holds past rising edge", tdo, 0);
      @(negedge tck); #1;
      chk(tdo == 1'b1, "R3 tdo moves on falling edge", tdo, 1);
      step(1, 0);
      chk(tdo_oe == 1'b0, "R3 tdo_oe off in Exit1-DR", tdo_oe, 0);
      step(1, 0); step(0, 0);
   endtask

   task automatic t_update_timing;
      logic [2:0] code = 3'b000;
      logic [2:0] cap;
      load_ir(3'b001, cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) step(i == 2, code[i]);
      step(0, 0);
      chk(outs_hiz == 1'b0, "R5 no change in Pause-IR", outs_hiz, 0);
      chk(tdo_oe == 1'b0, "R3 tdo_oe off in Pause-IR", tdo_oe, 0);
      step(1, 0); step(1, 0);
      chk(outs_hiz == 1'b0, "R5 no change in Update-IR", outs_hiz, 0);
      step(0, 0);
      chk(outs_hiz == 1'b1, "R5 takes effect leaving Update-IR", outs_hiz, 1);
   endtask

   task automatic t_boundary(input logic [2:0] code, input logic [NB-1:0] pv, input logic hiz);
      logic [127:0] o;
      logic [2:0] cap;
      pads = pv;
      load_ir(code, cap);
      chk(outs_hiz == hiz, "R10 float flag per code", outs_hiz, hiz);
      scan_dr(NB, '0, o);
      chk(o[NB-1:0] == pv, "R10 pad capture", o[NB-1:0], pv);
   endtask

   task automatic t_no_preload;
      logic [127:0] o;
      logic [2:0] cap;
      pads = {6'h2D, 64'h0123_4567_89AB_CDEF};
      load_ir(3'b100, cap);
      scan_dr(NB, {58'h0, ~pads}, o);
      chk(outs_hiz == 1'b0, "R11 flag stays low after Update-DR", outs_hiz, 0);
      scan_dr(NB, '0, o);
      chk(o[NB-1:0] == pads, "R11 no preload of shifted data", o[NB-1:0], pads);
   endtask

   task automatic t_reserved;
      logic [127:0] o;
      logic [2:0] cap;
      logic [127:0] din = 128'h6;
      logic [2:0] codes [3] = '{3'b011, 3'b101, 3'b110};
      for (int k = 0; k < 3; k++) begin
         load_ir(codes[k], cap);
         chk(outs_hiz == 1'b0, "R9 reserved code keeps flag low", outs_hiz, 0);
         scan_dr(4, din, o);
         chk(o[3:0] == {din[2:0], 1'b0}, "R9 reserved code acts as bypass", o[3:0], {din[2:0], 1'b0});
      end
   endtask

   task automatic t_five_ones;
      logic [127:0] o;
      logic [2:0] cap;
      load_ir(3'b010, cap);
      chk(outs_hiz == 1'b1, "R10 sample-Z floats", outs_hiz, 1);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 0);
      chk(outs_hiz == 1'b0, "R2 reset restores identification code", outs_hiz, 0);
      chk(tdo_oe == 1'b0, "R2 tdo_oe low in reset", tdo_oe, 0);
      step(0, 0);
      scan_dr(32, '0, o);
      chk(o[31:0] == EXP_ID, "R2 identification after 5 ones", o[31:0], EXP_ID);
   endtask

   initial begin
      repeat (3) @(negedge tck);
      #1;
      por_n = 1'b1;
      t_power_on();
      t_id_passthrough();
      t_ir_capture();
      t_bypass();
      t_tdo_edge();
      t_update_timing();
      t_boundary(3'b000, {6'h2D, 64'h0123_4567_89AB_CDEF}, 1'b1);
      t_boundary(3'b000, ~{6'h2D, 64'h0123_4567_89AB_CDEF}, 1'b1);
      t_boundary(3'b010, {6'h11, 64'hF0E1_D2C3_B4A5_9687}, 1'b1);
      t_boundary(3'b100, {6'h3A, 64'h5555_0000_FFFF_AAAA}, 1'b0);
      t_no_preload();
      t_reserved();
      t_five_ones();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule